// File: doc/BRIEF.md
# NAND Flash Host Bus Controller

This block sits on the host side of a raw NAND flash device with an 8-bit multiplexed bus. A request port accepts one operation at a time: page read, page program, block erase or status query, each with a column and a row address. The controller expands the request into the device's phase sequence. It sends command bytes while the command strobe level is high and address bytes while the address strobe level is high, then moves write or read data. Each byte is marked by a write-enable or read-enable pulse whose low and high widths are counted in system clocks. After each confirm command the controller waits on the device's busy line.

Page data enters and leaves on byte-wide valid/ready streams. On the write stream a byte is taken on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only while the controller is ready to start the next write pulse, so the source may pause at any time. On the read stream `rd_valid` rises when a byte has been fetched. `rd_data` is then held unchanged until the cycle in which `rd_ready` is high. No further read pulse is issued while a byte is waiting, so back-pressure simply stalls the device bus.

A program or erase is always followed by a status query. The outcome is reported on a one-cycle done strobe, together with the status byte and a timeout flag for a busy period that has run too long. The pad-level tri-state buffer is outside the block. The block presents the bus as separate out, out-enable and in signals.

Top module: `nand_host_ctrl`

## Requirements
- R1: A command byte is presented on `nand_dq_o` with `nand_dq_oe` high, `nand_cle` high and `nand_ale` low, and is marked by one `nand_we_n` pulse. Bus and levels stay stable while `nand_we_n` is low. The opcodes are: read 00h then 30h, program 80h then 10h, erase 60h then D0h, and status 70h.
- R2: An address byte is marked by a `nand_we_n` pulse with `nand_ale` high and `nand_cle` low. Read and program send four bytes in the order column low, column high, row low, row high. Erase sends two bytes, row low then row high. `nand_cle` and `nand_ale` are never high together.
- R3: Every `nand_we_n` pulse is low for exactly `WE_LOW` clocks and every `nand_re_n` pulse is low for exactly `RE_LOW` clocks. After each pulse the strobe stays high for at least `WE_HIGH` or `RE_HIGH` clocks. The two strobes are never low together.
- R4: `nand_dq_oe` is high only during command, address and write-data pulses. While `nand_re_n` is low, `nand_dq_oe`, `nand_cle` and `nand_ale` are all low.
- R5: Program takes exactly `PAGE_BYTES` bytes from the write stream, in arrival order, with one `nand_we_n` pulse per byte. It then sends 10h. `wr_ready` is low while a pulse is in progress and outside the data phase.
- R6: Read delivers `PAGE_BYTES` bytes on the read stream in device order, one `nand_re_n` pulse per byte. `rd_data` and `rd_valid` are held while `rd_valid` is high and `rd_ready` is low.
- R7: After a confirm command, no strobe is issued until the synchronised `nand_rb_n` has been seen high. Sampling starts only after `GUARD_CLKS` clocks.
- R8: After program or erase, the controller sends 70h and reads one status byte. `done_status` carries that byte. `done_ok` is 1 exactly when bit 0 of the byte is 0.
- R9: A status request sends only 70h, reads one byte and completes with that byte on `done_status`. `done_ok` follows bit 0 of the byte as in R8.
- R10: If `nand_rb_n` stays low for `BUSY_LIMIT` sampling clocks, the operation completes with `done_timeout` = 1 and `done_ok` = 0, and no further strobe is issued.
- R11: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale` and `nand_dq_oe` are low, and `op_ready` is high. `nand_ce_n` is low and `op_ready` low from the acceptance of a request until its done cycle.
- R12: `done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Controller idle, request accepted when valid |
| op_code | input | 2 | 0 read, 1 program, 2 erase, 3 status |
| op_col | input | 8*COL_BYTES | Column address |
| op_row | input | 8*ROW_BYTES | Row (page/block) address |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream byte taken |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read stream byte valid |
| rd_ready | input | 1 | Read stream consumer ready |
| rd_data | output | 8 | Read stream byte |
| done | output | 1 | One-cycle completion strobe |
| done_ok | output | 1 | Operation succeeded |
| done_timeout | output | 1 | Busy wait expired |
| done_status | output | 8 | Status byte read from device |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command strobe level |
| nand_ale | output | 1 | Address strobe level |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Bus value driven to pad |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus value sampled from pad |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The bench builds the controller with an 8-byte page, so every data phase, including the last byte and the move to confirm, is covered in a few dozen pulses. The strobe widths are set unequal (write low 3, high 2; read low 4, high 2), so a mix-up between the read and write timers shows as a width error. The guard is 6 clocks and the busy limit is 100 clocks. With these values a device model that stays busy for 20 clocks completes normally, while one that stays busy for 300 clocks reaches the timeout path.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_PROG   = 2'd1,
    OP_ERASE  = 2'd2,
    OP_STATUS = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_LEAD,
    PH_CONFIRM,
    PH_STATUS
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_ADDR,
    S_WDATA,
    S_BUSY,
    S_RDATA,
    S_STAT_RD,
    S_DONE
  } ctl_state_e;

  localparam logic [7:0] CMD_READ_LEAD  = 8'h00;
  localparam logic [7:0] CMD_READ_GO    = 8'h30;
  localparam logic [7:0] CMD_PROG_LEAD  = 8'h80;
  localparam logic [7:0] CMD_PROG_GO    = 8'h10;
  localparam logic [7:0] CMD_ERASE_LEAD = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
  localparam logic [7:0] CMD_STATUS     = 8'h70;

endpackage

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen #(
  parameter int LOW_WR  = 3,
  parameter int HIGH_WR = 3,
  parameter int LOW_RD  = 3,
  parameter int HIGH_RD = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_read,
  input  logic [7:0] dq_i,
  output logic       we_n,
  output logic       re_n,
  output logic       done,
  output logic [7:0] cap_data
);

  localparam int MAX_A = (LOW_WR > HIGH_WR) ? LOW_WR : HIGH_WR;
  localparam int MAX_B = (LOW_RD > HIGH_RD) ? LOW_RD : HIGH_RD;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  logic          active;
  logic          in_low;
  logic          rd_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      in_low   <= 1'b0;
      rd_q     <= 1'b0;
      cnt      <= '0;
      we_n     <= 1'b1;
      re_n     <= 1'b1;
      done     <= 1'b0;
      cap_data <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          in_low <= 1'b1;
          rd_q   <= is_read;
          cnt    <= is_read ? CW'(LOW_RD - 1) : CW'(LOW_WR - 1);
          we_n   <= is_read;
          re_n   <= !is_read;
        end
      end else if (in_low) begin
        if (cnt == '0) begin
          in_low <= 1'b0;
          we_n   <= 1'b1;
          re_n   <= 1'b1;
          cnt    <= rd_q ? CW'(HIGH_RD - 1) : CW'(HIGH_WR - 1);
          if (rd_q) cap_data <= dq_i;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        if (cnt == '0) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R3: the two enables are never low at once
  assert_no_dual_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  // R3: a new pulse never starts right after a falling strobe ends (high time kept)
  assert_high_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) || $rose(re_n)) |=> (we_n && re_n));

endmodule

// File: rtl/nand_busy_wait.sv
module nand_busy_wait #(
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_CLKS  = 8,
  parameter int LIMIT       = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rb_n,
  output logic ready,
  output logic timeout
);

  localparam int MAXV = (GUARD_CLKS > LIMIT) ? GUARD_CLKS : LIMIT;
  localparam int CW   = (MAXV > 1) ? $clog2(MAXV + 1) : 1;

  typedef enum logic [1:0] {BW_IDLE, BW_GUARD, BW_POLL} bw_e;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rb_s;
  bw_e                    ph;
  logic [CW-1:0]          cnt;

  assign rb_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rb_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= BW_IDLE;
      cnt     <= '0;
      ready   <= 1'b0;
      timeout <= 1'b0;
    end else begin
      ready   <= 1'b0;
      timeout <= 1'b0;
      case (ph)
        BW_IDLE: if (start) begin
          ph  <= BW_GUARD;
          cnt <= '0;
        end
        BW_GUARD: begin
          if (cnt >= CW'(GUARD_CLKS - 1)) begin
            ph  <= BW_POLL;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        BW_POLL: begin
          if (rb_s) begin
            ready <= 1'b1;
            ph    <= BW_IDLE;
          end else if (LIMIT != 0 && cnt == CW'(LIMIT - 1)) begin
            timeout <= 1'b1;
            ph      <= BW_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= BW_IDLE;
      endcase
    end
  end

  // R7: a wait is never re-armed while one is running
  assert_start_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (ph == BW_IDLE));

  // R10: success and expiry are exclusive outcomes
  assert_ready_xor_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && timeout));

endmodule

// File: rtl/nand_host_ctrl.sv
module nand_host_ctrl
  import nand_host_pkg::*;
#(
  parameter int PAGE_BYTES  = 2112,
  parameter int COL_BYTES   = 2,
  parameter int ROW_BYTES   = 2,
  parameter int WE_LOW      = 3,
  parameter int WE_HIGH     = 3,
  parameter int RE_LOW      = 3,
  parameter int RE_HIGH     = 3,
  parameter int GUARD_CLKS  = 8,
  parameter int BUSY_LIMIT  = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  output logic                   op_ready,
  input  logic [1:0]             op_code,
  input  logic [8*COL_BYTES-1:0] op_col,
  input  logic [8*ROW_BYTES-1:0] op_row,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [7:0]             wr_data,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [7:0]             rd_data,
  output logic                   done,
  output logic                   done_ok,
  output logic                   done_timeout,
  output logic [7:0]             done_status,
  output logic                   nand_ce_n,
  output logic                   nand_cle,
  output logic                   nand_ale,
  output logic                   nand_we_n,
  output logic                   nand_re_n,
  output logic [7:0]             nand_dq_o,
  output logic                   nand_dq_oe,
  input  logic [7:0]             nand_dq_i,
  input  logic                   nand_rb_n
);

  localparam int ADDR_BYTES = COL_BYTES + ROW_BYTES;
  localparam int CNT_W      = $clog2(PAGE_BYTES + 1);
  localparam int AB_W       = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] PAGE_N = CNT_W'(PAGE_BYTES);

  ctl_state_e              state;
  op_e                     op_q;
  phase_e                  phase_q;
  logic [7:0]              cmd_q;
  logic [8*ADDR_BYTES-1:0] addr_sh;
  logic [AB_W-1:0]         addr_left;
  logic [CNT_W-1:0]        byte_cnt;
  logic [7:0]              wbyte_q;
  logic                    launched;
  logic                    rd_valid_q;
  logic [7:0]              rd_data_q;
  logic [7:0]              status_q;
  logic                    timeout_q;

  logic       sb_start, sb_read, sb_done;
  logic [7:0] sb_cap;
  logic       bw_start, bw_ready, bw_timeout;

  nand_strobe_gen #(
    .LOW_WR (WE_LOW),
    .HIGH_WR(WE_HIGH),
    .LOW_RD (RE_LOW),
    .HIGH_RD(RE_HIGH)
  ) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sb_start),
    .is_read (sb_read),
    .dq_i    (nand_dq_i),
    .we_n    (nand_we_n),
    .re_n    (nand_re_n),
    .done    (sb_done),
    .cap_data(sb_cap)
  );

  nand_busy_wait #(
    .SYNC_STAGES(SYNC_STAGES),
    .GUARD_CLKS (GUARD_CLKS),
    .LIMIT      (BUSY_LIMIT)
  ) u_busy (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (bw_start),
    .rb_n   (nand_rb_n),
    .ready  (bw_ready),
    .timeout(bw_timeout)
  );

  // pulse launch decisions
  always_comb begin
    sb_start = 1'b0;
    sb_read  = 1'b0;
    case (state)
      S_CMD, S_ADDR: sb_start = !launched;
      S_WDATA:       sb_start = !launched && wr_valid && (byte_cnt != PAGE_N);
      S_RDATA: begin
        sb_start = !launched && !rd_valid_q && (byte_cnt != PAGE_N);
        sb_read  = 1'b1;
      end
      S_STAT_RD: begin
        sb_start = !launched;
        sb_read  = 1'b1;
      end
      default: ;
    endcase
  end

  assign bw_start = sb_done && (state == S_CMD) && (phase_q == PH_CONFIRM);
  assign wr_ready = (state == S_WDATA) && !launched && (byte_cnt != PAGE_N);

  assign op_ready   = (state == S_IDLE);
  assign nand_ce_n  = (state == S_IDLE);
  assign nand_cle   = (state == S_CMD);
  assign nand_ale   = (state == S_ADDR);
  assign nand_dq_oe = launched && (state == S_CMD || state == S_ADDR || state == S_WDATA);

  always_comb begin
    case (state)
      S_CMD:   nand_dq_o = cmd_q;
      S_ADDR:  nand_dq_o = addr_sh[7:0];
      S_WDATA: nand_dq_o = wbyte_q;
      default: nand_dq_o = 8'h00;
    endcase
  end

  assign rd_valid     = rd_valid_q;
  assign rd_data      = rd_data_q;
  assign done         = (state == S_DONE);
  assign done_timeout = timeout_q;
  assign done_status  = status_q;
  assign done_ok      = !timeout_q && !((op_q != OP_READ) && status_q[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      op_q       <= OP_READ;
      phase_q    <= PH_LEAD;
      cmd_q      <= '0;
      addr_sh    <= '0;
      addr_left  <= '0;
      byte_cnt   <= '0;
      wbyte_q    <= '0;
      launched   <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      status_q   <= '0;
      timeout_q  <= 1'b0;
    end else begin
      if (sb_start) launched <= 1'b1;
      if (sb_done)  launched <= 1'b0;
      if (rd_valid_q && rd_ready) rd_valid_q <= 1'b0;

      case (state)
        S_IDLE: if (op_valid) begin
          op_q      <= op_e'(op_code);
          status_q  <= '0;
          timeout_q <= 1'b0;
          byte_cnt  <= '0;
          state     <= S_CMD;
          if (op_e'(op_code) == OP_ERASE) begin
            addr_sh   <= {{(8*COL_BYTES){1'b0}}, op_row};
            addr_left <= AB_W'(ROW_BYTES);
          end else begin
            addr_sh   <= {op_row, op_col};
            addr_left <= AB_W'(ADDR_BYTES);
          end
          case (op_e'(op_code))
            OP_READ:  begin cmd_q <= CMD_READ_LEAD;  phase_q <= PH_LEAD;   end
            OP_PROG:  begin cmd_q <= CMD_PROG_LEAD;  phase_q <= PH_LEAD;   end
            OP_ERASE: begin cmd_q <= CMD_ERASE_LEAD; phase_q <= PH_LEAD;   end
            default:  begin cmd_q <= CMD_STATUS;     phase_q <= PH_STATUS; end
          endcase
        end

        S_CMD: if (sb_done) begin
          case (phase_q)
            PH_LEAD:    state <= S_ADDR;
            PH_CONFIRM: state <= S_BUSY;
            default:    state <= S_STAT_RD;
          endcase
        end

        S_ADDR: if (sb_done) begin
          addr_sh   <= addr_sh >> 8;
          addr_left <= addr_left - 1'b1;
          if (addr_left == AB_W'(1)) begin
            if (op_q == OP_PROG) begin
              state <= S_WDATA;
            end else begin
              cmd_q   <= (op_q == OP_READ) ? CMD_READ_GO : CMD_ERASE_GO;
              phase_q <= PH_CONFIRM;
              state   <= S_CMD;
            end
          end
        end

        S_WDATA: begin
          if (wr_valid && wr_ready) wbyte_q <= wr_data;
          if (sb_done) begin
            if (byte_cnt == PAGE_N - 1'b1) begin
              byte_cnt <= '0;
              cmd_q    <= CMD_PROG_GO;
              phase_q  <= PH_CONFIRM;
              state    <= S_CMD;
            end else begin
              byte_cnt <= byte_cnt + 1'b1;
            end
          end
        end

        S_BUSY: begin
          if (bw_timeout) begin
            timeout_q <= 1'b1;
            state     <= S_DONE;
          end else if (bw_ready) begin
            if (op_q == OP_READ) begin
              byte_cnt <= '0;
              state    <= S_RDATA;
            end else begin
              cmd_q   <= CMD_STATUS;
              phase_q <= PH_STATUS;
              state   <= S_CMD;
            end
          end
        end

        S_RDATA: begin
          if (sb_done) begin
            rd_data_q  <= sb_cap;
            rd_valid_q <= 1'b1;
            byte_cnt   <= byte_cnt + 1'b1;
          end else if (byte_cnt == PAGE_N && !rd_valid_q) begin
            state <= S_DONE;
          end
        end

        S_STAT_RD: if (sb_done) begin
          status_q <= sb_cap;
          state    <= S_DONE;
        end

        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: command and address levels are exclusive
  assert_cle_ale_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R4: the host never drives the bus during a read pulse
  assert_bus_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (!nand_dq_oe && !nand_cle && !nand_ale));

  // R4: a write pulse always has the bus driven
  assert_we_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  // R1: levels and bus value are steady while a write pulse is low
  assert_we_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |->
      ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_dq_o)));

  // R5: no write byte accepted while a pulse is in flight
  assert_wr_ready_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> nand_we_n);

  // R6: a pending read byte is held under back-pressure
  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R6: no read pulse starts while a byte waits for the consumer
  assert_no_re_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nand_re_n) && (state == S_RDATA)) |-> $past(!rd_valid));

  // R11: strobes only while the chip is selected
  assert_ce_selected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  // R12: completion lasts one cycle
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/nand_host_ctrl_tb.sv
`timescale 1ns/1ps
module nand_host_ctrl_tb;

  localparam int PB = 8;
  localparam int WL = 3, WH = 2, RL = 4, RH = 2;
  localparam int GD = 6, BL = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        op_valid = 1'b0, op_ready;
  logic [1:0]  op_code = '0;
  logic [15:0] op_col = '0, op_row = '0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [7:0]  wr_data = '0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        done, done_ok, done_timeout;
  logic [7:0]  done_status;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o, nand_dq_i;
  logic        nand_rb_n;

  nand_host_ctrl #(
    .PAGE_BYTES(PB), .COL_BYTES(2), .ROW_BYTES(2),
    .WE_LOW(WL), .WE_HIGH(WH), .RE_LOW(RL), .RE_HIGH(RH),
    .GUARD_CLKS(GD), .BUSY_LIMIT(BL), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
    .op_col(op_col), .op_row(op_row),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .done_ok(done_ok), .done_timeout(done_timeout),
    .done_status(done_status),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
    .nand_rb_n(nand_rb_n)
  );

  // ---------------- device model ----------------
  logic [7:0] store [0:3][0:PB-1];
  logic [7:0] pbuf  [0:PB-1];
  logic [7:0] cmd_log  [0:63];
  logic [7:0] addr_log [0:63];
  int ncmd = 0, naddr = 0, a_base = 0;
  int col_ptr = 0, busy_cnt = 0;
  int busy_len = 20;
  logic fail_next = 1'b0;
  logic status_mode = 1'b0;
  logic [7:0] status_reg = 8'hC0;
  logic we_prev = 1'b1, re_prev = 1'b1;
  int we_lo = 0, re_lo = 0, width_err = 0, oe_err = 0, busy_err = 0, re_pulses = 0;

  assign nand_rb_n = (busy_cnt == 0);
  assign nand_dq_i = !nand_re_n ? (status_mode ? status_reg : pbuf[col_ptr % PB]) : 8'h00;

  always @(posedge clk) begin
    if (rst_n) begin
      we_prev <= nand_we_n;
      re_prev <= nand_re_n;
      if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (!nand_we_n) we_lo <= we_lo + 1;
      if (!nand_re_n) re_lo <= re_lo + 1;
      if (busy_cnt > 0 && (!nand_we_n || !nand_re_n)) busy_err <= busy_err + 1;
      if (nand_dq_oe && !nand_re_n) oe_err <= oe_err + 1;
      if (!re_prev && nand_re_n) begin
        if (re_lo != RL) width_err <= width_err + 1;
        re_lo <= 0;
        re_pulses <= re_pulses + 1;
        if (!status_mode) col_ptr <= col_ptr + 1;
      end
      if (!we_prev && nand_we_n) begin
        if (we_lo != WL) width_err <= width_err + 1;
        we_lo <= 0;
        if (nand_cle) begin
          cmd_log[ncmd] <= nand_dq_o;
          ncmd <= ncmd + 1;
          case (nand_dq_o)
            8'h00, 8'h80, 8'h60: begin a_base <= naddr; status_mode <= 1'b0; col_ptr <= 0; end
            8'h30: begin
              for (int i = 0; i < PB; i++) pbuf[i] <= store[addr_log[a_base+2][1:0]][i];
              col_ptr <= 0;
              busy_cnt <= busy_len;
            end
            8'h10: begin
              for (int i = 0; i < PB; i++) store[addr_log[a_base+2][1:0]][i] <= pbuf[i];
              status_reg <= {7'b1100000, fail_next};
              busy_cnt <= busy_len;
            end
            8'hD0: begin
              for (int i = 0; i < PB; i++) store[addr_log[a_base][1:0]][i] <= 8'hFF;
              status_reg <= 8'hC0;
              busy_cnt <= busy_len;
            end
            8'h70: status_mode <= 1'b1;
            default: ;
          endcase
        end else if (nand_ale) begin
          addr_log[naddr] <= nand_dq_o;
          naddr <= naddr + 1;
        end else begin
          pbuf[col_ptr % PB] <= nand_dq_o;
          col_ptr <= col_ptr + 1;
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  int checks = 0, failures = 0;
  logic got_ok, got_to;
  logic [7:0] got_st;
  logic [7:0] rx [0:PB-1];
  int hold_err = 0;

  task automatic check(input bit cond, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] code, input logic [15:0] col, input logic [15:0] row);
    @(negedge clk);
    op_code = code; op_col = col; op_row = row; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check(!op_ready && !nand_ce_n, "R11", "busy after accept", {op_ready, nand_ce_n}, 0);
  endtask

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (!done && n < 5000) begin @(negedge clk); n++; end
    got_ok = done_ok; got_to = done_timeout; got_st = done_status;
    @(negedge clk);
    check(!done, "R12", "done one cycle", done, 0);
    check(op_ready && nand_ce_n, "R11", "idle after done", {op_ready, nand_ce_n}, 2'b11);
  endtask

  task automatic feed_page(input logic [7:0] seed);
    for (int i = 0; i < PB; i++) begin
      @(negedge clk);
      if (i % 2 == 1) begin wr_valid = 1'b0; repeat (3) @(negedge clk); end
      wr_valid = 1'b1; wr_data = seed + 8'(i * 7);
      while (!wr_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic sink_page(input bit throttle);
    int got = 0;
    int cyc = 0;
    while (got < PB) begin
      @(negedge clk);
      if (rd_valid && !rd_ready) begin
        logic [7:0] held;
        held = rd_data;
        @(negedge clk);
        if (!rd_valid || rd_data != held) hold_err++;
      end
      rd_ready = throttle ? (cyc % 3 == 2) : 1'b1;
      cyc++;
      if (rd_valid && rd_ready) begin rx[got] = rd_data; got++; end
    end
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(nand_ce_n && nand_we_n && nand_re_n, "R11", "strobes high at reset",
          {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    check(!nand_cle && !nand_ale && !nand_dq_oe && op_ready, "R11", "levels at reset",
          {nand_cle, nand_ale, nand_dq_oe, op_ready}, 4'b0001);
  endtask

  task automatic t_program(input logic [15:0] row, input logic fail, input logic [7:0] seed);
    int c0 = ncmd, a0 = naddr;
    fail_next = fail;
    issue(2'd1, 16'h0000, row);
    fork feed_page(seed); wait_done(); join
    check(ncmd - c0 == 3 && cmd_log[c0] == 8'h80 && cmd_log[c0+1] == 8'h10 && cmd_log[c0+2] == 8'h70,
          "R1", "program command order", {cmd_log[c0], cmd_log[c0+1], cmd_log[c0+2]}, 24'h801070);
    check(naddr - a0 == 4 && addr_log[a0] == 8'h00 && addr_log[a0+1] == 8'h00 &&
          addr_log[a0+2] == row[7:0] && addr_log[a0+3] == row[15:8],
          "R2", "program address bytes", {addr_log[a0+2], addr_log[a0+3]}, {row[7:0], row[15:8]});
    for (int i = 0; i < PB; i++)
      if (store[row[1:0]][i] != seed + 8'(i * 7))
        check(0, "R5", "programmed byte", store[row[1:0]][i], seed + 8'(i * 7));
    check(got_ok == !fail && got_st[0] == fail && !got_to, "R8", "program outcome",
          {got_ok, got_st}, {!fail, 7'b1100000, fail});
  endtask

  task automatic t_read(input logic [15:0] row, input bit throttle, input bit expect_erased,
                        input logic [7:0] seed);
    int c0 = ncmd;
    issue(2'd0, 16'h0000, row);
    fork sink_page(throttle); wait_done(); join
    check(cmd_log[c0] == 8'h00 && cmd_log[c0+1] == 8'h30 && ncmd - c0 == 2, "R1",
          "read command order", {cmd_log[c0], cmd_log[c0+1]}, 16'h0030);
    for (int i = 0; i < PB; i++) begin
      logic [7:0] e;
      e = expect_erased ? 8'hFF : seed + 8'(i * 7);
      if (rx[i] != e) check(0, "R6", "read byte", rx[i], e);
    end
    check(got_ok && !got_to, "R6", "read completes ok", {got_ok, got_to}, 2'b10);
    check(hold_err == 0, "R6", "held under back-pressure", hold_err, 0);
  endtask

  task automatic t_erase(input logic [15:0] row);
    int c0 = ncmd, a0 = naddr;
    issue(2'd2, 16'h0000, row);
    wait_done();
    check(ncmd - c0 == 3 && cmd_log[c0] == 8'h60 && cmd_log[c0+1] == 8'hD0 && cmd_log[c0+2] == 8'h70,
          "R1", "erase command order", {cmd_log[c0], cmd_log[c0+1], cmd_log[c0+2]}, 24'h60D070);
    check(naddr - a0 == 2 && addr_log[a0] == row[7:0] && addr_log[a0+1] == row[15:8],
          "R2", "erase row bytes", {addr_log[a0], addr_log[a0+1]}, {row[7:0], row[15:8]});
    check(got_ok && got_st == 8'hC0, "R8", "erase status", got_st, 8'hC0);
  endtask

  task automatic t_status();
    int c0 = ncmd, r0 = re_pulses;
    issue(2'd3, 16'h0000, 16'h0000);
    wait_done();
    check(ncmd - c0 == 1 && cmd_log[c0] == 8'h70 && re_pulses - r0 == 1, "R9",
          "status sequence", {cmd_log[c0], 8'(re_pulses - r0)}, 16'h7001);
    check(got_st == status_reg && got_ok == !status_reg[0], "R9", "status byte",
          {got_ok, got_st}, {!status_reg[0], status_reg});
  endtask

  task automatic t_timeout();
    int r0;
    busy_len = 300;
    issue(2'd0, 16'h0000, 16'h0001);
    wait_done();
    r0 = re_pulses;
    check(got_to && !got_ok, "R10", "timeout reported", {got_to, got_ok}, 2'b10);
    repeat (40) @(negedge clk);
    check(re_pulses == r0 && nand_we_n && nand_re_n, "R10", "no strobes after timeout",
          re_pulses - r0, 0);
    wait (busy_cnt == 0);
    busy_len = 20;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_program(16'h0A01, 1'b0, 8'h31);
    t_read(16'h0A01, 1'b1, 1'b0, 8'h31);
    t_erase(16'h0A01);
    t_read(16'h0A01, 1'b0, 1'b1, 8'h00);
    t_program(16'h0302, 1'b1, 8'h5C);
    t_status();
    t_timeout();
    check(width_err == 0, "R3", "strobe low widths", width_err, 0);
    check(oe_err == 0, "R4", "bus released on read pulses", oe_err, 0);
    check(busy_err == 0, "R7", "strobes while device busy", busy_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule